// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns timer events into two PWM output levels, A and B. The timer reports three kinds of event: counter at zero, counter at period, and counter equal to a compare value while counting up. Each output has its own action word. For each event, the word holds a 2-bit code that leaves the output alone, drives it low, drives it high, or toggles it. Output A reacts to compare-A matches and output B reacts to compare-B matches. A typical setup drives the output high on zero and on period and low on the compare match, which gives an edge-aligned duty cycle.

Software can also hold either output at a fixed level. It writes a pending force word. A reload mode decides when the pending word becomes the active force: at the next zero event, the next period event, either of those, or at the next tick. Nothing happens unless the tick enable is high. Event pulses and the reload of the force word both wait for a tick.

Each output is a four-state machine: `CH_LOW`, `CH_HIGH`, `CH_HELD_LOW` and `CH_HELD_HIGH`. Outside a tick, every state stays where it is. On a tick:
- An active force code of low moves the output to `CH_HELD_LOW`.
- An active force code of high moves it to `CH_HELD_HIGH`.
- Any other code ends the hold. The output then moves to `CH_LOW` or `CH_HIGH` according to the winning event action, which is applied to the current level (a held level counts as that level).

Top module: `pwm_aq_force`

## Requirements
- R1: After reset both outputs are low, all action codes are 00, the pending and active force words are 00 (no force) and the reload mode is 00 (load at zero).
- R2: An action code of 00 leaves the output unchanged, 01 drives it low, 10 drives it high and 11 inverts it. An action takes effect on the output one clock after the tick cycle that carries the event.
- R3: In an action word, the zero action sits at bits 1:0 and the period action at bits 3:2. Output A takes its compare action from bits 5:4 of its word and ignores bits 9:8. Output B takes its compare action from bits 9:8 of its word and ignores bits 5:4. A compare-B strobe never changes output A, and a compare-A strobe never changes output B.
- R4: When several events fall in one tick, the compare action wins over the period action, and the period action wins over the zero action.
- R5: In a cycle with the tick enable low, event and compare inputs have no effect, both outputs hold their level, and the active force word does not reload.
- R6: The force word has field A at bits 1:0 and field B at bits 3:2. Code 01 holds the output low, 10 holds it high, and 00 or 11 means no force. While a force is active it overrides every event action on that output.
- R7: The reload mode sits at bits 7:6. Code 00 loads the pending force at a zero tick, 01 at a period tick, 10 at either, and 11 at the next tick. A freshly loaded force controls the output in that same tick.
- R8: When a force is released, the output keeps the forced level until an event action changes it. A toggle acts on that level.
- R9: A write with wr_sel 0 loads action word A, 1 loads action word B, 2 loads the pending force word and 3 loads the reload mode. The write takes effect from the next clock. A reload in the same cycle as a force write transfers the previously stored pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base tick enable; qualifies all events and reloads |
| evt_zero | input | 1 | Counter reached zero |
| evt_period | input | 1 | Counter reached period |
| cmp_a_up | input | 1 | Counter equals compare A while counting up |
| cmp_b_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 action A, 1 action B, 2 force, 3 reload mode |
| wr_data | input | 10 | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Two pairs of functions can meet in a single tick.

The first pair is a compare strobe arriving together with a zero or period event. The bench sets up opposing actions on the two events and then pulses both in one tick. It judges the resulting level against the priority order, so a wrong priority gives the wrong level.

The second pair is a force-word write arriving in the cycle where the reload condition fires. The bench compares the outcome against a cycle-accurate behavioural model, which must show the old pending value taking control and the new one waiting for the next reload. Long random runs repeat both coincidences many times under every reload mode.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int FLD_W     = 2;
    localparam int NUM_OUT   = 2;
    localparam int WR_SEL_W  = 2;
    localparam int ZERO_LSB  = 0;
    localparam int PRD_LSB   = FLD_W;
    localparam int CMPA_LSB  = 2 * FLD_W;
    localparam int RLD_LSB   = 3 * FLD_W;
    localparam int CMPB_LSB  = 4 * FLD_W;
    localparam int WR_DATA_W = 5 * FLD_W;
    localparam int FRC_W     = NUM_OUT * FLD_W;

    typedef enum logic [FLD_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [FLD_W-1:0] {
        FRC_OFF     = 2'b00,
        FRC_LOW     = 2'b01,
        FRC_HIGH    = 2'b10,
        FRC_OFF_ALT = 2'b11
    } frc_e;

    typedef enum logic [FLD_W-1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef enum logic [WR_SEL_W-1:0] {
        WR_ACT_A  = 2'd0,
        WR_ACT_B  = 2'd1,
        WR_FORCE  = 2'd2,
        WR_RELOAD = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        CH_LOW,
        CH_HIGH,
        CH_HELD_LOW,
        CH_HELD_HIGH
    } ch_state_e;

    typedef struct packed {
        act_e on_cmp;
        act_e on_prd;
        act_e on_zero;
    } act_fields_t;

    function automatic int cmp_lsb(input int ch);
        return (ch == 0) ? CMPA_LSB : CMPB_LSB;
    endfunction

endpackage

// File: rtl/pwm_aq_force_ctl.sv
module pwm_aq_force_ctl
    import pwm_aq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic             wr_force,
    input  logic [FRC_W-1:0] force_data,
    input  logic             wr_reload,
    input  logic [FLD_W-1:0] reload_data,
    output logic [FRC_W-1:0] force_nxt,
    output logic [FRC_W-1:0] force_cur
);

    logic [FRC_W-1:0] pending_q;
    logic [FRC_W-1:0] active_q;
    rld_e             mode_q;
    logic             reload_hit;

    // Reload condition for the pending force word, per selected mode
    always_comb begin
        unique case (mode_q)
            RLD_ZERO:   reload_hit = evt_zero;
            RLD_PERIOD: reload_hit = evt_period;
            RLD_EITHER: reload_hit = evt_zero | evt_period;
            RLD_NOW:    reload_hit = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            active_q  <= '0;
            mode_q    <= RLD_ZERO;
        end else begin
            if (wr_force)
                pending_q <= force_data;
            if (wr_reload)
                mode_q <= rld_e'(reload_data);
            if (tick && reload_hit)
                active_q <= pending_q;
        end
    end

    // The force that governs this tick: a fresh load takes control at once
    assign force_nxt = (tick && reload_hit) ? pending_q : active_q;
    assign force_cur = active_q;

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
    import pwm_aq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        evt_zero,
    input  logic        evt_period,
    input  logic        evt_cmp,
    input  act_fields_t acts,
    input  frc_e        force_code,
    output logic        pwm
);

    ch_state_e state_q;
    ch_state_e state_d;
    act_e      win_act;
    logic      level_now;
    logic      level_evt;

    // Event priority: compare, then period, then zero
    always_comb begin
        if (evt_cmp)
            win_act = acts.on_cmp;
        else if (evt_period)
            win_act = acts.on_prd;
        else if (evt_zero)
            win_act = acts.on_zero;
        else
            win_act = ACT_NONE;
    end

    always_comb begin
        unique case (state_q)
            CH_LOW, CH_HELD_LOW:   level_now = 1'b0;
            CH_HIGH, CH_HELD_HIGH: level_now = 1'b1;
        endcase
    end

    always_comb begin
        unique case (win_act)
            ACT_NONE:   level_evt = level_now;
            ACT_LOW:    level_evt = 1'b0;
            ACT_HIGH:   level_evt = 1'b1;
            ACT_TOGGLE: level_evt = ~level_now;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (force_code)
                FRC_LOW:  state_d = CH_HELD_LOW;
                FRC_HIGH: state_d = CH_HELD_HIGH;
                FRC_OFF, FRC_OFF_ALT:
                          state_d = level_evt ? CH_HIGH : CH_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_LOW;
        else
            state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            CH_LOW, CH_HELD_LOW:   pwm = 1'b0;
            CH_HIGH, CH_HELD_HIGH: pwm = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
    import pwm_aq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 evt_zero,
    input  logic                 evt_period,
    input  logic                 cmp_a_up,
    input  logic                 cmp_b_up,
    input  logic                 wr_en,
    input  logic [WR_SEL_W-1:0]  wr_sel,
    input  logic [WR_DATA_W-1:0] wr_data,
    output logic                 pwm_a,
    output logic                 pwm_b
);

    act_fields_t [NUM_OUT-1:0] act_q;
    logic [NUM_OUT-1:0]        cmp_up;
    logic [NUM_OUT-1:0]        pwm_vec;
    logic [FRC_W-1:0]          force_nxt;
    logic [FRC_W-1:0]          force_cur;
    logic                      wr_force;
    logic                      wr_reload;

    assign cmp_up    = {cmp_b_up, cmp_a_up};
    assign wr_force  = wr_en && (wr_sel == WR_FORCE);
    assign wr_reload = wr_en && (wr_sel == WR_RELOAD);

    // Per-output action words; each output keeps only its own compare field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            for (int g = 0; g < NUM_OUT; g++) begin
                if (wr_en && (wr_sel == WR_SEL_W'(g))) begin
                    act_q[g].on_zero <= act_e'(wr_data[ZERO_LSB +: FLD_W]);
                    act_q[g].on_prd  <= act_e'(wr_data[PRD_LSB +: FLD_W]);
                    act_q[g].on_cmp  <= act_e'(wr_data[cmp_lsb(g) +: FLD_W]);
                end
            end
        end
    end

    pwm_aq_force_ctl u_force (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .evt_zero    (evt_zero),
        .evt_period  (evt_period),
        .wr_force    (wr_force),
        .force_data  (wr_data[0 +: FRC_W]),
        .wr_reload   (wr_reload),
        .reload_data (wr_data[RLD_LSB +: FLD_W]),
        .force_nxt   (force_nxt),
        .force_cur   (force_cur)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pwm_aq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .evt_zero   (evt_zero),
            .evt_period (evt_period),
            .evt_cmp    (cmp_up[g]),
            .acts       (act_q[g]),
            .force_code (frc_e'(force_nxt[g*FLD_W +: FLD_W])),
            .pwm        (pwm_vec[g])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

endmodule

// File: rtl/pwm_aq_force_chk.sv
module pwm_aq_force_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cmp_a_up,
    input logic       pwm_a,
    input logic       pwm_b,
    input logic [3:0] force_nxt,
    input logic [3:0] force_cur,
    input logic [1:0] a_cmp_act
);

    // R5
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    // R5
    hold_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(force_cur));

    // R6
    force_a_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_nxt[1:0] == 2'b10) |=> pwm_a);

    // R6
    force_a_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_nxt[1:0] == 2'b01) |=> !pwm_a);

    // R6
    force_b_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_nxt[3:2] == 2'b10) |=> pwm_b);

    // R4
    cmp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_a_up && (force_nxt[1:0] == 2'b00 || force_nxt[1:0] == 2'b11)
         && a_cmp_act == 2'b01) |=> !pwm_a);

endmodule

bind pwm_aq_force pwm_aq_force_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmp_a_up  (cmp_a_up),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .force_nxt (force_nxt),
    .force_cur (force_cur),
    .a_cmp_act (act_q[0].on_cmp)
);

// File: tb/pwm_aq_force_test.sv
module pwm_aq_force_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       evt_zero = 1'b0;
    logic       evt_period = 1'b0;
    logic       cmp_a_up = 1'b0;
    logic       cmp_b_up = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [9:0] wr_data = 10'd0;
    logic       pwm_a;
    logic       pwm_b;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_zero[2];
    int m_prd[2];
    int m_cmp[2];
    int m_pend;
    int m_act;
    int m_mode;
    int m_out[2];

    always #2 clk = ~clk;

    pwm_aq_force uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
        .evt_period(evt_period), .cmp_a_up(cmp_a_up), .cmp_b_up(cmp_b_up),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic int word(int z, int p, int ca, int cb);
        return z | (p << 2) | (ca << 4) | (cb << 8);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_zero[c] = 0; m_prd[c] = 0; m_cmp[c] = 0; m_out[c] = 0;
        end
        m_pend = 0; m_act = 0; m_mode = 0;
    endtask

    task automatic model_edge();
        int act_new;
        bit load;
        int wd;
        if (!rst_n) begin
            model_reset();
            return;
        end
        act_new = m_act;
        if (tick) begin
            case (m_mode)
                0: load = evt_zero;
                1: load = evt_period;
                2: load = evt_zero || evt_period;
                default: load = 1;
            endcase
            if (load) act_new = m_pend;
            for (int c = 0; c < 2; c++) begin
                int f;
                int a;
                bit cmp;
                f = (act_new >> (2 * c)) & 3;
                cmp = (c == 0) ? cmp_a_up : cmp_b_up;
                if (f == 1) m_out[c] = 0;
                else if (f == 2) m_out[c] = 1;
                else begin
                    if (cmp) a = m_cmp[c];
                    else if (evt_period) a = m_prd[c];
                    else if (evt_zero) a = m_zero[c];
                    else a = 0;
                    if (a == 1) m_out[c] = 0;
                    else if (a == 2) m_out[c] = 1;
                    else if (a == 3) m_out[c] = 1 - m_out[c];
                end
            end
        end
        if (wr_en) begin
            wd = int'(wr_data);
            case (wr_sel)
                2'd0: begin m_zero[0] = wd & 3; m_prd[0] = (wd >> 2) & 3; m_cmp[0] = (wd >> 4) & 3; end
                2'd1: begin m_zero[1] = wd & 3; m_prd[1] = (wd >> 2) & 3; m_cmp[1] = (wd >> 8) & 3; end
                2'd2: m_pend = wd & 15;
                default: m_mode = (wd >> 6) & 3;
            endcase
        end
        m_act = act_new;
    endtask

    task automatic compare();
        total++;
        if (int'(pwm_a) != m_out[0]) begin
            bad++;
            $display("FAIL %s pwm_a actual=%0d expected=%0d at %0t", tag, pwm_a, m_out[0], $time);
        end
        total++;
        if (int'(pwm_b) != m_out[1]) begin
            bad++;
            $display("FAIL %s pwm_b actual=%0d expected=%0d at %0t", tag, pwm_b, m_out[1], $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 10'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic ev(bit t, bit z, bit p, bit ca, bit cb);
        tick = t; evt_zero = z; evt_period = p; cmp_a_up = ca; cmp_b_up = cb;
        step();
        tick = 0; evt_zero = 0; evt_period = 0; cmp_a_up = 0; cmp_b_up = 0;
    endtask

    initial begin
        model_reset();
        // R1: reset state
        tag = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();
        ev(1, 1, 0, 1, 1);

        // R3: field placement, each output ignores the other compare field
        tag = "R3";
        wr(0, word(2, 2, 1, 3));
        wr(1, word(2, 2, 3, 1));
        ev(1, 1, 0, 0, 0);
        ev(1, 0, 0, 0, 1);
        ev(1, 0, 0, 1, 0);
        ev(1, 0, 0, 0, 1);

        // R2: edge-aligned waveform with idle gaps
        tag = "R2";
        for (int i = 0; i < 48; i++) begin
            int cnt;
            cnt = (i / 2) % 6;
            ev(i % 2 == 0, cnt == 0, cnt == 5, cnt == 2, cnt == 4);
        end
        wr(0, word(3, 0, 0, 0));
        repeat (3) ev(1, 1, 0, 0, 0);
        wr(1, word(0, 0, 0, 3));
        repeat (3) ev(1, 0, 0, 0, 1);

        // R4: coincident events
        tag = "R4";
        wr(0, word(2, 1, 1, 0));
        wr(1, word(2, 1, 0, 2));
        ev(1, 1, 0, 1, 0);
        ev(1, 1, 0, 0, 0);
        ev(1, 1, 1, 0, 0);
        ev(1, 0, 1, 0, 1);
        ev(1, 1, 1, 1, 1);

        // R5: events without tick are ignored
        tag = "R5";
        wr(0, word(3, 3, 3, 0));
        repeat (4) ev(0, 1, 1, 1, 1);
        wr(3, 3 << 6);
        wr(2, 2);
        repeat (3) ev(0, 1, 0, 1, 0);

        // R6/R7: immediate force, overrides every action
        tag = "R6";
        ev(1, 0, 0, 0, 0);
        wr(2, 2 | (1 << 2));
        ev(1, 1, 1, 1, 1);
        ev(1, 1, 0, 1, 1);
        // R8: release with code 11, toggle acts on held level
        tag = "R8";
        wr(0, word(3, 0, 1, 0));
        wr(2, 3 | (3 << 2));
        ev(1, 0, 0, 0, 0);
        ev(1, 1, 0, 0, 0);
        ev(1, 1, 0, 0, 0);

        // R7: deferred reload modes
        tag = "R7";
        wr(0, word(0, 0, 0, 0));
        wr(3, 0);
        wr(2, 1);
        ev(1, 0, 1, 0, 0);
        ev(1, 1, 0, 0, 0);
        wr(3, 1 << 6);
        wr(2, 2 | (2 << 2));
        ev(1, 1, 0, 0, 0);
        ev(1, 0, 1, 0, 0);
        wr(3, 2 << 6);
        wr(2, 1 | (1 << 2));
        ev(1, 0, 0, 1, 1);
        ev(1, 1, 0, 0, 0);
        wr(2, 0);
        ev(1, 0, 1, 0, 0);

        // R9: write coinciding with reload transfers old pending value
        tag = "R9";
        wr(3, 3 << 6);
        wr(2, 2);
        tick = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 10'd1;
        step();
        tick = 0; wr_en = 0;
        ev(1, 0, 0, 0, 0);
        wr(2, 0);
        ev(1, 0, 0, 0, 0);

        // R4/R9 random mix
        tag = "R9 random";
        for (int i = 0; i < 4000; i++) begin
            tick = 1'($urandom_range(0, 3) != 0);
            evt_zero = 1'($urandom_range(0, 3) == 0);
            evt_period = 1'($urandom_range(0, 3) == 0);
            cmp_a_up = 1'($urandom_range(0, 3) == 0);
            cmp_b_up = 1'($urandom_range(0, 3) == 0);
            wr_en = 1'($urandom_range(0, 5) == 0);
            wr_sel = 2'($urandom_range(0, 3));
            wr_data = 10'($urandom);
            step();
        end
        tick = 0; evt_zero = 0; evt_period = 0; cmp_a_up = 0; cmp_b_up = 0; wr_en = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule